// File: doc/BRIEF.md
# Flash Write Completion Poller

This block runs on the controller side of a parallel NOR flash. Once a program or erase command sequence starts on the bus, it decides when the internal operation has finished. It watches the write strobes of that sequence and waits until the status bits are meaningful. Then it reads the target location again and again over a simple request/acknowledge port. Each returned word is judged by one of two methods: bit 6 stops alternating between reads, or bit 7 shows the final value. An optional ready/busy level from the device can hold off reads while the device reports busy.

Completion and the bus are asynchronous, so a read can land at the moment the operation ends. That read can carry a clean status bit next to stale data. When status says finished but the word differs from what a finished location must hold, the poller does not give up at once. It reads twice more and accepts the operation only if both reads are clean. A configurable limit on polls turns a hung device into a reported timeout. The result is a one-cycle done or fail pulse.

Top module: `wrpoll_top`

## Requirements
- R1: After an accepted `start`, no read is issued until the 4th `wr_stb` pulse for a program (`op_erase`=0) or the 6th for an erase (`op_erase`=1).
- R2: Every read holds `rd_req` high with `rd_addr` equal to the `tgt_addr` captured at `start` until `rd_ack`; later changes on `tgt_addr` and `exp_data` have no effect.
- R3: In bit-7 mode (`mode_data`=1) for a program, a read reports completion when its bit 7 equals bit 7 of the expected data; otherwise polling continues.
- R4: In bit-7 mode for an erase, a read reports completion when bit 7 is 1; the finished word expected for an erase is all ones, and `exp_data` is ignored.
- R5: In bit-6 mode (`mode_data`=0), completion is reported when bit 6 of a read equals bit 6 of the read just before it; the first read of a run never reports completion.
- R6: If a read reports completion but the whole word differs from the finished value, exactly two more reads follow; `done` if both equal the finished value, else `fail` with `timeout` low.
- R7: With `use_rdy`=1, no read is issued while `rdy_in` is 0 (busy), and each such cycle counts as one poll; with `use_rdy`=0, `rdy_in` has no effect.
- R8: When `MAX_POLLS` polls (unfinished status reads plus busy cycles) pass without completion, the block raises `fail` with `timeout` high.
- R9: `done` or `fail` is high for exactly one cycle, never both, after which `busy` is low; `start` is ignored while `busy` is high.
- R10: During and after reset, `rd_req`, `busy`, `done`, `fail` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that arms a new run when idle |
| mode_data | input | 1 | 1 = bit-7 method, 0 = bit-6 method |
| op_erase | input | 1 | 1 = erase, 0 = program |
| use_rdy | input | 1 | Honour the ready/busy level |
| tgt_addr | input | AW | Location to poll |
| exp_data | input | DW | Word being programmed |
| wr_stb | input | 1 | One pulse per write strobe of the command sequence |
| rdy_in | input | 1 | Device ready (1) or busy (0) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | DW | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle failure pulse |
| timeout | output | 1 | Qualifies `fail` as a poll-limit failure |

## Verification
A modelled device returns a chosen number of in-progress words and then a chosen first finished word and a follow-up word. Read latency varies from run to run. A clean finished word tells the plain completion paths apart for program and erase under both methods. A finished status bit next to a wrong data bit exercises the two confirmation reads, and the follow-up word decides whether they rescue the run or confirm the failure. Endless in-progress words, and a busy level that never lifts, reach the poll limit. Further runs check the strobe gate, the busy-level gate and its bypass, and a restart attempted mid-run.

// File: rtl/wrpoll_pkg.sv
// Package: shared types of the write completion poller.
// Assumes: nothing beyond IEEE 1800-2017.
package wrpoll_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_POLL,
        ST_RD_STAT,
        ST_RD_CONF,
        ST_DONE,
        ST_FAIL
    } wp_state_e;

    // Run configuration captured at start
    typedef struct packed {
        logic mode_data;
        logic op_erase;
        logic use_rdy;
    } wp_cfg_t;

endpackage

// File: rtl/wrpoll_strobe_gate.sv
// Module: wrpoll_strobe_gate
// Counts write strobes after a run is armed and signals the strobe that makes
// the status bits meaningful (PROG_STROBES for a program, ERASE_STROBES for
// an erase). Assumes wr_stb is a clean single-cycle pulse per strobe.
module wrpoll_strobe_gate #(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic op_erase,
    input  logic wr_stb,
    output logic reached
);
    localparam int MAXS = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
    localparam int CW   = $clog2(MAXS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;

    // Select the strobe count required by the operation kind
    always_comb need = op_erase ? CW'(ERASE_STROBES) : CW'(PROG_STROBES);

    // Flag the strobe that completes the required count
    always_comb reached = count_en && wr_stb && ((cnt_q + 1'b1) == need);

    // Strobe counter, cleared at each new run
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (count_en && wr_stb)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wrpoll_judge.sv
// Module: wrpoll_judge
// Pure combinational verdict on one returned word: whether the status bits
// say the operation finished, and whether the whole word equals the finished
// value (expected data for a program, all ones for an erase).
// Assumes DW > both TOG_BIT and DPOLL_BIT.
module wrpoll_judge #(
    parameter int DW        = 16,
    parameter int TOG_BIT   = 6,
    parameter int DPOLL_BIT = 7
) (
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] exp_data,
    input  logic          mode_data,
    input  logic          op_erase,
    input  logic          prev_tog,
    input  logic          have_prev,
    output logic          stat_done,
    output logic          word_ok
);
    logic [DW-1:0] final_word;
    logic          dpoll_done;
    logic          tog_done;

    // Value a finished location must read back
    always_comb final_word = op_erase ? {DW{1'b1}} : exp_data;

    // Bit-7 method: true data bit for program, one for erase
    always_comb dpoll_done = op_erase ? rd_data[DPOLL_BIT]
                                      : (rd_data[DPOLL_BIT] == exp_data[DPOLL_BIT]);

    // Bit-6 method: no change against the previous read
    always_comb tog_done = have_prev && (rd_data[TOG_BIT] == prev_tog);

    // Final verdicts
    always_comb begin
        stat_done = mode_data ? dpoll_done : tog_done;
        word_ok   = (rd_data == final_word);
    end

endmodule

// File: rtl/wrpoll_poll_cnt.sv
// Module: wrpoll_poll_cnt
// Counts unsuccessful polls of one run and flags the configured limit.
// Assumes inc is never asserted once limit is high.
module wrpoll_poll_cnt #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic limit
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_q;

    // Limit reached when the count equals the maximum
    always_comb limit = (cnt_q == CW'(MAX_POLLS));

    // Poll counter, cleared at each new run
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (inc && !limit)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wrpoll_top.sv
// Module: wrpoll_top
// Write completion poller. Armed by start, it waits for the required write
// strobes, then polls the target location with single reads until status
// bit 6 (no toggle) or bit 7 (final value) shows completion. An ambiguous
// finish gets two confirmation reads. The optional ready/busy level gates
// reads. A poll limit ends the run with a timeout.
// Assumes rd_ack is only asserted while rd_req is high, and rdy_in is
// synchronous to clk.
module wrpoll_top
    import wrpoll_pkg::*;
#(
    parameter int DW            = 16,
    parameter int AW            = 20,
    parameter int MAX_POLLS     = 16,
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6,
    parameter int TOG_BIT       = 6,
    parameter int DPOLL_BIT     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_data,
    input  logic          op_erase,
    input  logic          use_rdy,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] exp_data,
    input  logic          wr_stb,
    input  logic          rdy_in,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          timeout
);
    wp_state_e     state_q, state_d;
    wp_cfg_t       cfg_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic          prev_tog_q, have_prev_q;
    logic          conf_idx_q, conf_bad_q, tmo_q;

    logic launch, gate_open, stat_done, word_ok, poll_limit, poll_inc, rdy_block;

    // Accept a start only when idle
    always_comb launch = start && (state_q == ST_IDLE);

    // Busy level holds off reads only when enabled
    always_comb rdy_block = cfg_q.use_rdy && !rdy_in;

    wrpoll_strobe_gate #(
        .PROG_STROBES (PROG_STROBES),
        .ERASE_STROBES(ERASE_STROBES)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .count_en(state_q == ST_ARM),
        .op_erase(cfg_q.op_erase),
        .wr_stb  (wr_stb),
        .reached (gate_open)
    );

    wrpoll_judge #(
        .DW       (DW),
        .TOG_BIT  (TOG_BIT),
        .DPOLL_BIT(DPOLL_BIT)
    ) u_judge (
        .rd_data  (rd_data),
        .exp_data (exp_q),
        .mode_data(cfg_q.mode_data),
        .op_erase (cfg_q.op_erase),
        .prev_tog (prev_tog_q),
        .have_prev(have_prev_q),
        .stat_done(stat_done),
        .word_ok  (word_ok)
    );

    // Count busy-level waits and unfinished status reads as polls
    always_comb poll_inc = ((state_q == ST_POLL) && !poll_limit && rdy_block)
                        || ((state_q == ST_RD_STAT) && rd_ack && !stat_done);

    wrpoll_poll_cnt #(
        .MAX_POLLS(MAX_POLLS)
    ) u_polls (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(launch),
        .inc  (poll_inc),
        .limit(poll_limit)
    );

    // Next-state decision of the sequencer
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (launch) state_d = ST_ARM;
            ST_ARM:     if (gate_open) state_d = ST_POLL;
            ST_POLL: begin
                if (poll_limit)      state_d = ST_FAIL;
                else if (!rdy_block) state_d = ST_RD_STAT;
            end
            ST_RD_STAT: begin
                if (rd_ack) begin
                    if (!stat_done)   state_d = ST_POLL;
                    else if (word_ok) state_d = ST_DONE;
                    else              state_d = ST_RD_CONF;
                end
            end
            ST_RD_CONF: begin
                if (rd_ack && conf_idx_q)
                    state_d = (conf_bad_q || !word_ok) ? ST_FAIL : ST_DONE;
            end
            ST_DONE:    state_d = ST_IDLE;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the run configuration, address and expected word at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
            exp_q  <= '0;
        end else if (launch) begin
            cfg_q  <= '{mode_data: mode_data, op_erase: op_erase, use_rdy: use_rdy};
            addr_q <= tgt_addr;
            exp_q  <= exp_data;
        end
    end

    // Remember bit 6 of the last status read for the toggle method
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if ((state_q == ST_RD_STAT) && rd_ack) begin
            prev_tog_q  <= rd_data[TOG_BIT];
            have_prev_q <= 1'b1;
        end
    end

    // Track the two confirmation reads and whether either was unclean
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_idx_q <= 1'b0;
            conf_bad_q <= 1'b0;
        end else if ((state_q == ST_RD_STAT) && rd_ack) begin
            conf_idx_q <= 1'b0;
            conf_bad_q <= 1'b0;
        end else if ((state_q == ST_RD_CONF) && rd_ack) begin
            conf_idx_q <= 1'b1;
            conf_bad_q <= conf_bad_q || !word_ok;
        end
    end

    // Remember that the failure came from the poll limit
    always_ff @(posedge clk) begin
        if (!rst_n || launch)
            tmo_q <= 1'b0;
        else if ((state_q == ST_POLL) && poll_limit)
            tmo_q <= 1'b1;
    end

    // Output decode
    always_comb begin
        rd_req  = (state_q == ST_RD_STAT) || (state_q == ST_RD_CONF);
        rd_addr = addr_q;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        fail    = (state_q == ST_FAIL);
        timeout = (state_q == ST_FAIL) && tmo_q;
    end

endmodule

// File: rtl/wrpoll_chk.sv
// Module: wrpoll_chk
// Property checker for wrpoll_top, attached by bind. Keeps its own view of
// the run (strobe count since start, captured mode) from the ports only.
module wrpoll_chk #(
    parameter int AW            = 20,
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_erase,
    input logic          use_rdy,
    input logic          wr_stb,
    input logic          rdy_in,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          timeout
);
    localparam logic [3:0] NEED_P = 4'(PROG_STROBES);
    localparam logic [3:0] NEED_E = 4'(ERASE_STROBES);

    logic       erase_l, rdy_l, first_pending;
    logic [3:0] stb_cnt;

    // Observe the run from the ports: mode, strobes, first read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_l       <= 1'b0;
            rdy_l         <= 1'b0;
            first_pending <= 1'b0;
            stb_cnt       <= '0;
        end else if (start && !busy) begin
            erase_l       <= op_erase;
            rdy_l         <= use_rdy;
            first_pending <= 1'b1;
            stb_cnt       <= '0;
        end else begin
            if (busy && first_pending && wr_stb && (stb_cnt != 4'hF))
                stb_cnt <= stb_cnt + 1'b1;
            if (rd_req)
                first_pending <= 1'b0;
        end
    end

    AST_STROBES_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && first_pending) |-> (stb_cnt >= (erase_l ? NEED_E : NEED_P))); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R2

    AST_RDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && rdy_l) |-> $past(rdy_in)); // R7

    AST_TIMEOUT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> fail); // R8

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail})); // R9

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> (!done && !fail && !busy)); // R9

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy); // R10

endmodule

bind wrpoll_top wrpoll_chk #(
    .AW           (AW),
    .PROG_STROBES (PROG_STROBES),
    .ERASE_STROBES(ERASE_STROBES)
) u_chk (.*);

// File: tb/sim_wrpoll_top.sv
`timescale 1ns/1ps
module sim_wrpoll_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode_data = 1'b0, op_erase = 1'b0, use_rdy = 1'b0;
    logic [19:0] tgt_addr = '0;
    logic [15:0] exp_data = '0;
    logic        wr_stb = 1'b0, rdy_in = 1'b1;
    logic        rd_req, rd_ack;
    logic [19:0] rd_addr;
    logic [15:0] rd_data;
    logic        busy, done, fail, timeout;

    always #2.5 clk = ~clk;

    wrpoll_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_data(mode_data),
        .op_erase(op_erase), .use_rdy(use_rdy), .tgt_addr(tgt_addr),
        .exp_data(exp_data), .wr_stb(wr_stb), .rdy_in(rdy_in),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout)
    );

    int n_tests = 0, n_fail = 0;

    // Device model state for the current run
    logic        cur_er = 1'b0;
    logic [15:0] cur_exp = 16'hC35A, cur_w1 = '0, cur_w2 = '0;
    logic [19:0] cur_addr = '0;
    int          cur_lat = 0, cur_nb = 0, reads = 0, addr_err = 0, wait_n = 0;
    logic        r_done, r_fail, r_tmo;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(input int k);
        logic [15:0] w;
        if (k < cur_nb) begin
            w    = 16'h2A15;
            w[7] = cur_er ? 1'b0 : ~cur_exp[7];
            w[6] = k[0];
        end else if (k == cur_nb) w = cur_w1;
        else                      w = cur_w2;
        return w;
    endfunction

    // Device model: acknowledges reads after cur_lat waiting cycles
    initial begin
        rd_ack  = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_ack) rd_ack = 1'b0;
            else if (rd_req) begin
                if (rd_addr !== cur_addr) addr_err++;
                if (wait_n < cur_lat) wait_n++;
                else begin
                    rd_ack  = 1'b1;
                    rd_data = model_word(reads);
                    reads++;
                    wait_n  = 0;
                end
            end else wait_n = 0;
        end
    end

    // Start a run and give its command strobes; checks the strobe gate
    task automatic launch(input logic md, input logic er, input logic ur, input int lat,
                          input int nb, input logic [15:0] w1, input logic [15:0] w2,
                          input logic [19:0] a);
        int need;
        cur_er = er; cur_lat = lat; cur_nb = nb; cur_w1 = w1; cur_w2 = w2;
        cur_addr = a; reads = 0; addr_err = 0;
        need = er ? 6 : 4;
        @(negedge clk);
        start = 1'b1; mode_data = md; op_erase = er; use_rdy = ur;
        tgt_addr = a; exp_data = cur_exp;
        @(negedge clk);
        start = 1'b0; tgt_addr = ~a; exp_data = 16'h0000;
        for (int i = 0; i < need - 1; i++) begin
            wr_stb = 1'b1; @(negedge clk);
            wr_stb = 1'b0; @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check("R1 no read before last strobe", reads + int'(rd_req), 0);
        wr_stb = 1'b1; @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Wait for the result pulse and check it lasts one cycle
    task automatic collect();
        int n = 0;
        while (!(done || fail) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        r_done = done; r_fail = fail; r_tmo = timeout;
        @(negedge clk);
        check("R9 one-cycle result then idle", int'({done, fail, busy}), 0);
    endtask

    typedef struct packed {
        logic        md;
        logic        er;
        logic [1:0]  lat;
        logic [7:0]  nb;
        logic [15:0] w1;
        logic [15:0] w2;
        logic        xd;
        logic        xt;
        logic [7:0]  xr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'd0, 8'd3,  16'hC35A, 16'hC35A, 1'b1, 1'b0, 8'd4},  // R3
        '{1'b1, 1'b1, 2'd1, 8'd2,  16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 8'd3},  // R4
        '{1'b1, 1'b0, 2'd2, 8'd1,  16'hC35B, 16'hC35A, 1'b1, 1'b0, 8'd4},  // R6
        '{1'b1, 1'b0, 2'd0, 8'd1,  16'hC35B, 16'hC35B, 1'b0, 1'b0, 8'd4},  // R6
        '{1'b0, 1'b0, 2'd1, 8'd4,  16'hC35A, 16'hC35A, 1'b1, 1'b0, 8'd5},  // R5
        '{1'b0, 1'b1, 2'd0, 8'd3,  16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 8'd5},  // R5
        '{1'b0, 1'b0, 2'd2, 8'd2,  16'hC35A, 16'hC35A, 1'b1, 1'b0, 8'd3},  // R5
        '{1'b0, 1'b0, 2'd0, 8'd2,  16'hC25A, 16'hC35A, 1'b1, 1'b0, 8'd5},  // R6
        '{1'b1, 1'b0, 2'd0, 8'd20, 16'hC35A, 16'hC35A, 1'b0, 1'b1, 8'd16}, // R8
        '{1'b0, 1'b0, 2'd1, 8'd20, 16'hC35A, 16'hC35A, 1'b0, 1'b1, 8'd16}, // R8
        '{1'b1, 1'b1, 2'd0, 8'd0,  16'hFFFE, 16'hFFFF, 1'b1, 1'b0, 8'd3},  // R4
        '{1'b1, 1'b1, 2'd1, 8'd0,  16'hFFFE, 16'hFFFE, 1'b0, 1'b0, 8'd3}   // R6
    };

    function automatic string vtag(input int v);
        case (v)
            0:       return "R3";
            1, 10:   return "R4";
            4, 5, 6: return "R5";
            8, 9:    return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        // R10: reset state
        repeat (4) @(negedge clk);
        check("R10 reset outputs", int'({rd_req, busy, done, fail, timeout}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", int'({rd_req, busy, done, fail, timeout}), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v].md, VECS[v].er, 1'b0, int'(VECS[v].lat), int'(VECS[v].nb),
                   VECS[v].w1, VECS[v].w2, 20'h05A00 + 20'(v));
            collect();
            check({vtag(v), " done"},    int'(r_done), int'(VECS[v].xd));
            check({vtag(v), " fail"},    int'(r_fail), int'(!VECS[v].xd));
            check({vtag(v), " timeout"}, int'(r_tmo),  int'(VECS[v].xt));
            check({vtag(v), " reads"},   reads,        int'(VECS[v].xr));
            check("R2 read address",     addr_err,     0);
        end

        // R7: busy level holds off reads, then release
        rdy_in = 1'b0;
        launch(1'b1, 1'b0, 1'b1, 0, 0, 16'hC35A, 16'hC35A, 20'h0ABCD);
        repeat (6) @(negedge clk);
        check("R7 no read while busy level low", reads + int'(rd_req), 0);
        rdy_in = 1'b1;
        collect();
        check("R7 done after ready", int'(r_done), 1);
        check("R7 one read after ready", reads, 1);

        // R8: busy level never lifts
        rdy_in = 1'b0;
        launch(1'b1, 1'b0, 1'b1, 0, 0, 16'hC35A, 16'hC35A, 20'h01234);
        collect();
        check("R8 fail on busy timeout", int'({r_fail, r_tmo}), 3);
        check("R7 no reads while busy", reads, 0);

        // R7: level ignored when disabled
        launch(1'b1, 1'b0, 1'b0, 0, 2, 16'hC35A, 16'hC35A, 20'h04321);
        collect();
        rdy_in = 1'b1;
        check("R7 level ignored done", int'(r_done), 1);
        check("R7 level ignored reads", reads, 3);

        // R9: start while busy is ignored
        launch(1'b0, 1'b0, 1'b0, 1, 6, 16'hC35A, 16'hC35A, 20'h11111);
        repeat (4) @(negedge clk);
        start = 1'b1; tgt_addr = 20'h22222; mode_data = 1'b1; op_erase = 1'b1;
        @(negedge clk);
        start = 1'b0;
        collect();
        check("R9 restart ignored done", int'(r_done), 1);
        check("R9 restart ignored reads", reads, 7);
        check("R9 restart ignored address", addr_err, 0);

        summary();
    end

endmodule